// File: doc/BRIEF.md
# Masked Digital I/O Port Bank

This block holds the output state of 48 digital I/O lines and presents them as six byte-wide ports on a small register bus. Each register is one byte wide and occupies its own 32-bit word, and only the low byte carries data. Software writes a port to set the eight output latches behind it. Reading a port returns what the lines carry. For a line group that software treats as an input, the read shows the live pin levels. For an output group, the read shows the latched value.

A write-mask register sits in the eighth slot of the bank. A set bit in this register marks its port as an input, and the block then ignores writes to that port. This keeps an output latch from being loaded with a value that would fight an external driver. The mask register also feeds a mode-unlock detector. The block leaves reset in its standard mode. It moves to an enhanced mode, and stays there until reset, only after a fixed four-byte sequence is written to the mask slot. No other bus access may come between those writes, and interrupts must stay disabled throughout. The enhanced-mode flag is exported so that other logic can enable its extra functions.

Top module: `dio_port_bank`

## Requirements
- R1: While `rst_n` is low and after it is released, `pin_out` is zero, the mask register reads 0x00, `enh_mode` is 0 and `rd_data` is 0x00.
- R2: Port n (n = 0..5) sits at byte address 0x200 + 4·n and drives lines 8n..8n+7. A read strobe (`acc_valid`=1, `acc_write`=0) loads `rd_data` on the next clock edge. `rd_data` holds its value in every cycle that has no read strobe.
- R3: A write strobe to port n whose mask bit is clear loads `wr_data` into `pin_out[8n+7:8n]` on that clock edge.
- R4: The mask register is at 0x21C. Bit n (n = 0..5) masks port n, and a set bit makes writes to that port have no effect. Bits 7:6 always read 0.
- R5: A read of port n returns `pin_in[8n+7:8n]` when mask bit n is set, and the latched output byte when the bit is clear.
- R6: A read of slot 6 (0x218) or of any address from 0x220 to 0x2FC returns 0x00. Writes to these addresses leave `pin_out` unchanged.
- R7: Writing 0x07, 0x0D, 0x06 and 0x12 to 0x21C in that order, with `irq_en` low, sets `enh_mode` on the edge of the last write. `enh_mode` then stays 1 until reset, whatever else is written.
- R8: A read of any address (0x21C included), or a write to any address other than 0x21C, between sequence writes returns the detector to idle. A wrong byte also returns it to idle, except that a wrong byte equal to 0x07 counts as the first step of a new sequence.
- R9: In any cycle with `irq_en` high, the detector returns to idle, including on the cycle of a sequence write.
- R10: A reset asserted after `enh_mode` was set returns the block to standard mode with `pin_out` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| acc_valid | input | 1 | Single-cycle access strobe |
| acc_write | input | 1 | 1 = write, 0 = read, qualified by `acc_valid` |
| acc_addr | input | 12 | Byte address of the access |
| wr_data | input | 8 | Write data byte |
| irq_en | input | 1 | Interrupt enable state, high aborts the unlock sequence |
| pin_in | input | 48 | Live levels of the 48 I/O lines |
| rd_data | output | 8 | Registered read data |
| pin_out | output | 48 | Output latches of the 48 I/O lines |
| enh_mode | output | 1 | 1 once the enhanced mode is unlocked |

## Verification
The assertions assume that `acc_valid` is a single-cycle pulse with `acc_write`, `acc_addr` and `wr_data` stable and known while it is high. They also assume that `irq_en` is a clean level synchronous to `clk`. The bench changes every input only on the falling edge and leaves an idle cycle after each strobe, so each access is seen by exactly one rising edge. `pin_in` is held at a fixed, distinct pattern per port while readback is examined, so that a read of the pins and a read of the latch give different values.

// File: rtl/dio_pkg.sv
package dio_pkg;

  localparam int unsigned SLOT_COUNT = 8;
  localparam int unsigned SLOT_W     = $clog2(SLOT_COUNT);
  localparam int unsigned SLOT_LSB   = 2;
  localparam int unsigned MASK_SLOT  = SLOT_COUNT - 1;
  localparam int unsigned SEQ_LEN    = 4;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_STEP1 = 2'd1,
    UL_STEP2 = 2'd2,
    UL_STEP3 = 2'd3
  } unlock_state_e;

  localparam logic [7:0] UNLOCK_SEQ [SEQ_LEN] = '{8'h07, 8'h0D, 8'h06, 8'h12};

endpackage

// File: rtl/dio_bus_decode.sv
module dio_bus_decode
  import dio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_PORTS = 6,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'h200
) (
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [ADDR_W-1:0]     acc_addr,
  output logic                  rd_strobe,
  output logic                  bank_hit,
  output logic [SLOT_W-1:0]     slot,
  output logic [NUM_PORTS-1:0]  port_wr,
  output logic                  mask_wr,
  output logic                  seq_abort
);

  localparam int unsigned SPAN_LSB = SLOT_LSB + SLOT_W;
  localparam logic [ADDR_W-1:0] SPAN_MASK = {{(ADDR_W-SPAN_LSB){1'b1}}, {SPAN_LSB{1'b0}}};
  localparam logic [SLOT_W-1:0] MASK_IDX  = SLOT_W'(MASK_SLOT);

  logic wr_strobe;

  assign wr_strobe = acc_valid & acc_write;
  assign rd_strobe = acc_valid & ~acc_write;
  assign slot      = acc_addr[SPAN_LSB-1:SLOT_LSB];
  assign bank_hit  = ((acc_addr & SPAN_MASK) == BANK_BASE) &&
                     (acc_addr[SLOT_LSB-1:0] == '0);

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port_sel
      localparam logic [SLOT_W-1:0] PIDX = SLOT_W'(p);
      assign port_wr[p] = wr_strobe & bank_hit & (slot == PIDX);
    end
  endgenerate

  assign mask_wr   = wr_strobe & bank_hit & (slot == MASK_IDX);
  assign seq_abort = acc_valid & ~mask_wr;

endmodule

// File: rtl/dio_port_latch.sv
module dio_port_latch #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              masked,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] pin_byte,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] read_byte
);

  logic              load_en;
  logic [PORT_W-1:0] latch_d;

  assign load_en = wr_en & ~masked;

  always_comb begin
    latch_d = latch_q;
    if (load_en) latch_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (load_en) begin
      latch_q <= latch_d;
    end
  end

  assign read_byte = masked ? pin_byte : latch_q;

endmodule

// File: rtl/dio_unlock_fsm.sv
module dio_unlock_fsm
  import dio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic       seq_abort,
  input  logic       irq_en,
  input  logic [7:0] wr_data,
  output logic       enh_mode
);

  unlock_state_e state_q, state_d;
  logic          enh_q, enh_d;
  logic          byte_ok;
  logic          byte_first;

  always_comb begin
    unique case (state_q)
      UL_IDLE:  byte_ok = (wr_data == UNLOCK_SEQ[0]);
      UL_STEP1: byte_ok = (wr_data == UNLOCK_SEQ[1]);
      UL_STEP2: byte_ok = (wr_data == UNLOCK_SEQ[2]);
      default:  byte_ok = (wr_data == UNLOCK_SEQ[3]);
    endcase
    byte_first = (wr_data == UNLOCK_SEQ[0]);
  end

  always_comb begin
    state_d = state_q;
    enh_d   = enh_q;
    if (irq_en) begin
      state_d = UL_IDLE;
    end else if (mask_wr) begin
      if (byte_ok) begin
        unique case (state_q)
          UL_IDLE:  state_d = UL_STEP1;
          UL_STEP1: state_d = UL_STEP2;
          UL_STEP2: state_d = UL_STEP3;
          default: begin
            state_d = UL_IDLE;
            enh_d   = 1'b1;
          end
        endcase
      end else if (byte_first) begin
        state_d = UL_STEP1;
      end else begin
        state_d = UL_IDLE;
      end
    end else if (seq_abort) begin
      state_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UL_IDLE;
      enh_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      enh_q   <= enh_d;
    end
  end

  assign enh_mode = enh_q;

endmodule

// File: rtl/dio_port_bank.sv
module dio_port_bank
  import dio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'h200
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          acc_valid,
  input  logic                          acc_write,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [PORT_W-1:0]             wr_data,
  input  logic                          irq_en,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [PORT_W-1:0]             rd_data,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out,
  output logic                          enh_mode
);

  localparam int unsigned PAD_W = PORT_W - NUM_PORTS;

  logic                 rd_strobe;
  logic                 bank_hit;
  logic [SLOT_W-1:0]    slot;
  logic [NUM_PORTS-1:0] port_wr;
  logic                 mask_wr;
  logic                 seq_abort;

  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic [PORT_W-1:0]    slot_rd [SLOT_COUNT];
  logic [PORT_W-1:0]    rd_q, rd_d;

  dio_bus_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_PORTS (NUM_PORTS),
    .BANK_BASE (BANK_BASE)
  ) u_decode (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .rd_strobe (rd_strobe),
    .bank_hit  (bank_hit),
    .slot      (slot),
    .port_wr   (port_wr),
    .mask_wr   (mask_wr),
    .seq_abort (seq_abort)
  );

  // Write-mask register, one bit per data port
  always_comb begin
    mask_d = mask_q;
    if (mask_wr) mask_d = wr_data[NUM_PORTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= mask_d;
    end
  end

  // Port latches and per-slot read sources
  genvar s;
  generate
    for (s = 0; s < SLOT_COUNT; s++) begin : g_slot
      if (s < NUM_PORTS) begin : g_data
        logic [PORT_W-1:0] latch_q;
        dio_port_latch #(
          .PORT_W (PORT_W)
        ) u_latch (
          .clk       (clk),
          .rst_n     (rst_n),
          .wr_en     (port_wr[s]),
          .masked    (mask_q[s]),
          .wr_data   (wr_data),
          .pin_byte  (pin_in[s*PORT_W +: PORT_W]),
          .latch_q   (latch_q),
          .read_byte (slot_rd[s])
        );
        assign pin_out[s*PORT_W +: PORT_W] = latch_q;
      end else if (s == MASK_SLOT) begin : g_mask
        assign slot_rd[s] = {{PAD_W{1'b0}}, mask_q};
      end else begin : g_empty
        assign slot_rd[s] = '0;
      end
    end
  endgenerate

  // Registered read path
  always_comb begin
    rd_d = rd_q;
    if (rd_strobe) rd_d = bank_hit ? slot_rd[slot] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_strobe) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  dio_unlock_fsm u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .seq_abort (seq_abort),
    .irq_en    (irq_en),
    .wr_data   (wr_data),
    .enh_mode  (enh_mode)
  );

endmodule

// File: rtl/dio_port_bank_chk.sv
module dio_port_bank_chk #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8,
  parameter logic [ADDR_W-1:0] BANK_BASE = 12'h200
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_valid,
  input logic                        acc_write,
  input logic [ADDR_W-1:0]           acc_addr,
  input logic [PORT_W-1:0]           wr_data,
  input logic                        irq_en,
  input logic [PORT_W-1:0]           rd_data,
  input logic [NUM_PORTS*PORT_W-1:0] pin_out,
  input logic                        enh_mode,
  input logic [NUM_PORTS-1:0]        mask_q
);

  localparam logic [ADDR_W-1:0] SEL_ADDR   = BANK_BASE + ADDR_W'(28);
  localparam logic [ADDR_W-1:0] EMPTY_ADDR = BANK_BASE + ADDR_W'(24);
  localparam logic [ADDR_W-1:0] HOLE_LO    = BANK_BASE + ADDR_W'(32);
  localparam logic [ADDR_W-1:0] HOLE_HI    = BANK_BASE + ADDR_W'(252);

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port_chk
      localparam logic [ADDR_W-1:0] PADDR = BANK_BASE + ADDR_W'(4 * p);
      // R4
      masked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == PADDR && mask_q[p])
        |=> $stable(pin_out[p*PORT_W +: PORT_W]));
      // R3
      open_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr == PADDR && !mask_q[p])
        |=> pin_out[p*PORT_W +: PORT_W] == $past(wr_data));
    end
  endgenerate

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> $stable(rd_data));

  // R6
  empty_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == EMPTY_ADDR) |=> rd_data == '0);

  // R6
  hole_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr >= HOLE_LO && acc_addr <= HOLE_HI)
    |=> $stable(pin_out));

  // R7
  enh_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> enh_mode);

  // R7
  enh_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(acc_valid && acc_write && acc_addr == SEL_ADDR &&
                              wr_data == 8'h12 && !irq_en));

  // R4
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == SEL_ADDR)
    |=> rd_data[PORT_W-1:NUM_PORTS] == '0);

endmodule

bind dio_port_bank dio_port_bank_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .BANK_BASE (BANK_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .wr_data   (wr_data),
  .irq_en    (irq_en),
  .rd_data   (rd_data),
  .pin_out   (pin_out),
  .enh_mode  (enh_mode),
  .mask_q    (mask_q)
);

// File: tb/tb_dio_port_bank.sv
module tb_dio_port_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [11:0] acc_addr;
  logic [7:0]  wr_data;
  logic        irq_en;
  logic [47:0] pin_in;
  logic [7:0]  rd_data;
  logic [47:0] pin_out;
  logic        enh_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dio_port_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .wr_data   (wr_data),
    .irq_en    (irq_en),
    .pin_in    (pin_in),
    .rd_data   (rd_data),
    .pin_out   (pin_out),
    .enh_mode  (enh_mode)
  );

  // {check, write, addr, wdata, expected, req}
  localparam int NVEC = 21;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 12'h200, 8'h11, 8'h00, 4'd3},  // R3 port 0
    {1'b0, 1'b1, 12'h204, 8'h22, 8'h00, 4'd3},  // R3 port 1
    {1'b0, 1'b1, 12'h214, 8'h66, 8'h00, 4'd3},  // R3 port 5
    {1'b1, 1'b0, 12'h200, 8'h00, 8'h11, 4'd3},  // R3 latch readback
    {1'b1, 1'b0, 12'h204, 8'h00, 8'h22, 4'd2},  // R2 port spacing
    {1'b1, 1'b0, 12'h214, 8'h00, 8'h66, 4'd2},  // R2 last port
    {1'b0, 1'b1, 12'h21C, 8'hFF, 8'h00, 4'd4},  // R4 mask all
    {1'b1, 1'b0, 12'h21C, 8'h00, 8'h3F, 4'd4},  // R4 upper bits zero
    {1'b0, 1'b1, 12'h200, 8'h99, 8'h00, 4'd4},  // R4 blocked write
    {1'b1, 1'b0, 12'h200, 8'h00, 8'hF0, 4'd5},  // R5 pins shown
    {1'b1, 1'b0, 12'h214, 8'h00, 8'hA5, 4'd5},  // R5 pins shown
    {1'b0, 1'b1, 12'h21C, 8'h01, 8'h00, 4'd4},  // R4 mask port 0 only
    {1'b1, 1'b0, 12'h204, 8'h00, 8'h22, 4'd5},  // R5 latch shown
    {1'b1, 1'b0, 12'h200, 8'h00, 8'hF0, 4'd5},  // R5 pins shown
    {1'b0, 1'b1, 12'h21C, 8'h00, 8'h00, 4'd4},  // R4 unmask
    {1'b1, 1'b0, 12'h200, 8'h00, 8'h11, 4'd4},  // R4 blocked write kept old
    {1'b0, 1'b1, 12'h218, 8'h77, 8'h00, 4'd6},  // R6 slot 6 write
    {1'b1, 1'b0, 12'h218, 8'h00, 8'h00, 4'd6},  // R6 slot 6 reads zero
    {1'b0, 1'b1, 12'h220, 8'h55, 8'h00, 4'd6},  // R6 hole write
    {1'b1, 1'b0, 12'h220, 8'h00, 8'h00, 4'd6},  // R6 hole read
    {1'b1, 1'b0, 12'h2FC, 8'h00, 8'h00, 4'd6}   // R6 hole top
  };

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; wr_data = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic seq_byte(input logic [7:0] d);
    do_acc(1'b1, 12'h21C, d);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
    wr_data = '0; irq_en = 1'b0;
    pin_in = 48'hA5_5A_3C_C3_0F_F0;
    repeat (3) @(negedge clk);
    check("R1 pin_out in reset", pin_out, 48'h0);
    check("R1 rd_data in reset", {40'h0, rd_data}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 enh_mode after reset", {47'h0, enh_mode}, 48'h0);
    do_acc(1'b0, 12'h21C, 8'h00);
    check("R1 mask reads zero", {40'h0, rd_data}, 48'h0);

    for (int i = 0; i < NVEC; i++) begin
      do_acc(VEC[i][32], VEC[i][31:20], VEC[i][19:12]);
      if (VEC[i][33])
        check($sformatf("vector %0d (R%0d) rd_data", i, VEC[i][3:0]),
              {40'h0, rd_data}, {40'h0, VEC[i][11:4]});
    end
    check("R3 pin_out after vectors", pin_out, 48'h66_00_00_00_22_11);
    do_acc(1'b1, 12'h208, 8'hC3);
    check("R2 rd_data held over write", {40'h0, rd_data}, 48'h0);

    // R7 full sequence
    do_reset();
    seq_byte(8'h07); seq_byte(8'h0D); seq_byte(8'h06);
    check("R7 not yet enhanced", {47'h0, enh_mode}, 48'h0);
    seq_byte(8'h12);
    check("R7 enhanced after sequence", {47'h0, enh_mode}, 48'h1);
    seq_byte(8'h00);
    do_acc(1'b0, 12'h200, 8'h00);
    irq_en = 1'b1; @(negedge clk); irq_en = 1'b0;
    check("R7 enhanced sticky", {47'h0, enh_mode}, 48'h1);
    do_acc(1'b1, 12'h204, 8'h3C);
    // R10
    do_reset();
    check("R10 standard after reset", {47'h0, enh_mode}, 48'h0);
    check("R10 pin_out cleared", pin_out, 48'h0);

    // R8 read of another port aborts
    seq_byte(8'h07); seq_byte(8'h0D);
    do_acc(1'b0, 12'h200, 8'h00);
    seq_byte(8'h06); seq_byte(8'h12);
    check("R8 read between aborts", {47'h0, enh_mode}, 48'h0);

    // R8 read of mask slot aborts
    do_reset();
    seq_byte(8'h07); seq_byte(8'h0D); seq_byte(8'h06);
    do_acc(1'b0, 12'h21C, 8'h00);
    seq_byte(8'h12);
    check("R8 mask read aborts", {47'h0, enh_mode}, 48'h0);

    // R8 wrong byte aborts
    do_reset();
    seq_byte(8'h07); seq_byte(8'h0D); seq_byte(8'h05); seq_byte(8'h06); seq_byte(8'h12);
    check("R8 wrong byte aborts", {47'h0, enh_mode}, 48'h0);

    // R8 write to other port aborts
    do_reset();
    seq_byte(8'h07);
    do_acc(1'b1, 12'h218, 8'h00);
    seq_byte(8'h0D); seq_byte(8'h06); seq_byte(8'h12);
    check("R8 other write aborts", {47'h0, enh_mode}, 48'h0);

    // R8 wrong 0x07 restarts
    do_reset();
    seq_byte(8'h07); seq_byte(8'h0D); seq_byte(8'h07);
    seq_byte(8'h0D); seq_byte(8'h06); seq_byte(8'h12);
    check("R8 07 restarts sequence", {47'h0, enh_mode}, 48'h1);

    // R9 irq_en pulse between writes aborts
    do_reset();
    seq_byte(8'h07); seq_byte(8'h0D);
    irq_en = 1'b1; @(negedge clk); irq_en = 1'b0;
    seq_byte(8'h06); seq_byte(8'h12);
    check("R9 irq pulse aborts", {47'h0, enh_mode}, 48'h0);

    // R9 irq_en held during writes
    do_reset();
    irq_en = 1'b1;
    seq_byte(8'h07); seq_byte(8'h0D); seq_byte(8'h06); seq_byte(8'h12);
    irq_en = 1'b0;
    check("R9 irq held blocks unlock", {47'h0, enh_mode}, 48'h0);

    done = 1;
    summary();
    $finish;
  end

endmodule